// File: doc/BRIEF.md
# Read-Only SPI Pipeline Slave

This block lets an external SPI master read a sensor channel's FIFO. The master holds chip select low and sends 16 clocks. The block shifts out one status byte and then the data byte at the head of the FIFO, most significant bit first. The SPI mode has the clock idle low. The host samples on falling clock edges, and the block updates its output only after rising edges. The first bit is already on the line after chip select goes low and before the first rising clock edge.

The upper nibble of the status byte is a rolling check counter. It advances each time chip select is released, so consecutive reads always show different values and the host can see that the link is alive. The FIFO is popped only after a read that ran its full 16 clocks. A read that stops early leaves the FIFO untouched. Chip select and the serial clock are oversampled by the system clock through two-stage synchronisers, and edges are detected after synchronisation. With a 100 MHz system clock, the block supports serial clocks of 8 MHz or slower.

Top module: `spi_pipe_rd`

## Requirements
- R1: While chip select is inactive, `miso_oe_o` is 0 and `miso_o` is 0. Serial clock edges have no effect.
- R2: The status byte is sent first. Its bits [7:4] are the check nibble, bit 3 is the FIFO-empty flag, and bits [2:0] are `status_i`. All of these are captured when chip select becomes active.
- R3: A frame is 16 bits sent MSB first: the status byte, then the data byte from `fifo_data_i`. Bit 0 of the frame is valid before the first rising clock edge. Bit k (k ≥ 1) is valid after rising edge k+1 and stays valid until the host samples it on falling edge k+1.
- R4: The check nibble is 0 after reset. It increments by one on every chip-select release and wraps from 15 to 0.
- R5: A read that saw all 16 falling clock edges produces exactly one single-cycle `fifo_pop_o` pulse after chip select is released.
- R6: A read released after fewer than 16 falling edges produces no `fifo_pop_o` pulse.
- R7: When `fifo_empty_i` is 1 at capture, the data byte is 0x00 and status bit 3 is 1.
- R8: While driven, `miso_o` changes only in the system clock cycle that follows a detected rising serial clock edge.
- R9: `miso_oe_o` goes high on the third system clock rising edge after `ss_ni` falls, and goes low on the third edge after `ss_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ss_ni | input | 1 | SPI chip select, active low, asynchronous |
| sclk_i | input | 1 | SPI serial clock, asynchronous, idles low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the MISO pad; 0 means high impedance |
| status_i | input | 3 | Channel status bits placed in status bits [2:0] |
| fifo_data_i | input | 8 | Data byte at the FIFO head |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_pop_o | output | 1 | Single-cycle FIFO pop request |

## Verification
A wrong bit count or shift state shows up within one serial clock period: a bit appears one position early or late, or the pop is missing or extra when chip select is released. A faulty check counter shows in the upper status nibble of the very next read. A slip in the wrap from 15 to 0 appears within sixteen reads. A wrong capture of the empty flag or the status bits corrupts the first byte of the affected read, so the bench compares every bit of every frame against a model built from inputs that change with each read.

// File: rtl/spi_pipe_pkg.sv
package spi_pipe_pkg;
  localparam int unsigned CHK_W  = 4;
  localparam int unsigned STAT_W = 3;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned SYNC_N = 2;
endpackage

// File: rtl/spi_pipe_sync.sv
module spi_pipe_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int unsigned CHAIN_W = STAGES * W;

  logic [CHAIN_W-1:0] chain_q;
  logic [W-1:0]       prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
      prev_q  <= chain_q[CHAIN_W-1 -: W];
    end
  end

  assign q_o    = chain_q[CHAIN_W-1 -: W];
  assign rise_o = q_o & ~prev_q;
  assign fall_o = ~q_o & prev_q;
endmodule

// File: rtl/spi_pipe_chk_cnt.sv
module spi_pipe_chk_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;  // natural wrap
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spi_pipe_shift.sv
module spi_pipe_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               clr_i,
  input  logic               rise_i,
  input  logic               fall_i,
  output logic               bit_o,
  output logic               active_o,
  output logic               done_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (act_q) begin
      // first rising edge keeps bit 0 on the line
      if (rise_i && cnt_q != '0) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      if (fall_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o    = sh_q[FRAME_W-1];
  assign active_o = act_q;
  assign done_o   = (cnt_q == LAST);
endmodule

// File: rtl/spi_pipe_rd.sv
module spi_pipe_rd
  import spi_pipe_pkg::*;
#(
  parameter int unsigned CHK_BITS  = CHK_W,
  parameter int unsigned STAT_BITS = STAT_W,
  parameter int unsigned DATA_BITS = DATA_W,
  parameter int unsigned SYNC_LEN  = SYNC_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ss_ni,
  input  logic                 sclk_i,
  output logic                 miso_o,
  output logic                 miso_oe_o,
  input  logic [STAT_BITS-1:0] status_i,
  input  logic [DATA_BITS-1:0] fifo_data_i,
  input  logic                 fifo_empty_i,
  output logic                 fifo_pop_o
);
  localparam int unsigned FRAME_W = CHK_BITS + 1 + STAT_BITS + DATA_BITS;

  logic [1:0] pins_q, pins_rise, pins_fall;
  logic       ss_rise, ss_fall, sclk_rise, sclk_fall;
  logic [CHK_BITS-1:0] nib;
  logic [FRAME_W-1:0]  frame;
  logic       sh_bit, sh_act, sh_done;
  logic       pop_q;

  // bit 1: chip select (idle high), bit 0: serial clock (idle low)
  spi_pipe_sync #(.W(2), .STAGES(SYNC_LEN), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ss_ni, sclk_i}),
    .q_o    (pins_q),
    .rise_o (pins_rise),
    .fall_o (pins_fall)
  );

  assign ss_fall   = pins_fall[1];
  assign ss_rise   = pins_rise[1];
  assign sclk_rise = pins_rise[0];
  assign sclk_fall = pins_fall[0];

  spi_pipe_chk_cnt #(.W(CHK_BITS)) u_chk_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (ss_rise),
    .cnt_o  (nib)
  );

  assign frame = {nib, fifo_empty_i, status_i,
                  fifo_empty_i ? {DATA_BITS{1'b0}} : fifo_data_i};

  spi_pipe_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ss_fall),
    .frame_i  (frame),
    .clr_i    (ss_rise),
    .rise_i   (sclk_rise),
    .fall_i   (sclk_fall),
    .bit_o    (sh_bit),
    .active_o (sh_act),
    .done_o   (sh_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pop_q <= 1'b0;
    else         pop_q <= ss_rise & sh_act & sh_done;
  end

  assign miso_o     = sh_act & sh_bit;
  assign miso_oe_o  = sh_act;
  assign fifo_pop_o = pop_q;
endmodule

// File: rtl/spi_pipe_rd_chk.sv
module spi_pipe_rd_chk #(
  parameter int unsigned CHK_BITS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                miso_o,
  input logic                miso_oe_o,
  input logic                fifo_pop_o,
  input logic                ss_rise_i,
  input logic                ss_fall_i,
  input logic                sclk_rise_i,
  input logic [CHK_BITS-1:0] nib_i
);
  // R1
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);

  // R4
  nib_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_rise_i |=> nib_i == CHK_BITS'($past(nib_i) + 1'b1));

  // R4
  nib_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_rise_i |=> $stable(nib_i));

  // R5
  pop_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !fifo_pop_o);

  // R6
  pop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !miso_oe_o);

  // R8
  miso_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_oe_o && $past(miso_oe_o) && !$past(sclk_rise_i)) |-> $stable(miso_o));

  // R9
  oe_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_fall_i |=> miso_oe_o);

  // R9
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_rise_i |=> !miso_oe_o);
endmodule

bind spi_pipe_rd spi_pipe_rd_chk #(.CHK_BITS(CHK_BITS)) u_rd_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .miso_o      (miso_o),
  .miso_oe_o   (miso_oe_o),
  .fifo_pop_o  (fifo_pop_o),
  .ss_rise_i   (ss_rise),
  .ss_fall_i   (ss_fall),
  .sclk_rise_i (sclk_rise),
  .nib_i       (nib)
);

// File: tb/sim_spi_pipe_rd.sv
`timescale 1ns/1ps
module sim_spi_pipe_rd;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ss_ni = 1'b1;
  logic sclk_i = 1'b0;
  logic [2:0] status_i = '0;
  logic [7:0] fifo_data_i = '0;
  logic fifo_empty_i = 1'b0;
  logic miso_o, miso_oe_o, fifo_pop_o;

  int checks = 0;
  int errors = 0;
  int pop_cnt = 0;
  logic [3:0] nib_m = 4'd0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  spi_pipe_rd u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ss_ni(ss_ni), .sclk_i(sclk_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .status_i(status_i),
    .fifo_data_i(fifo_data_i), .fifo_empty_i(fifo_empty_i),
    .fifo_pop_o(fifo_pop_o)
  );

  always @(posedge clk_i) if (fifo_pop_o) pop_cnt++;

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic xfer(input int nb, input logic [2:0] st, input logic [7:0] dat, input logic emp);
    logic [15:0] exp;
    int pops0;
    string tag;
    exp = {nib_m, emp, st, emp ? 8'h00 : dat};
    status_i = st; fifo_data_i = dat; fifo_empty_i = emp;
    pops0 = pop_cnt;
    @(negedge clk_i) ss_ni = 1'b0;
    wait_n(2);
    chk("R9", {15'd0, miso_oe_o}, 16'd0);
    wait_n(1);
    chk("R9", {15'd0, miso_oe_o}, 16'd1);
    wait_n(3);
    chk("R3", {15'd0, miso_o}, {15'd0, exp[15]});
    for (int k = 0; k < nb; k++) begin
      sclk_i = 1'b1;
      wait_n(6);
      if (k < 4)       tag = "R4";
      else if (k < 8)  tag = "R2";
      else if (emp)    tag = "R7";
      else             tag = "R3";
      chk(tag, {15'd0, miso_o}, {15'd0, exp[15-k]});
      sclk_i = 1'b0;
      wait_n(6);
    end
    ss_ni = 1'b1;
    wait_n(2);
    chk("R9", {15'd0, miso_oe_o}, 16'd1);
    wait_n(1);
    chk("R9", {15'd0, miso_oe_o}, 16'd0);
    wait_n(4);
    chk("R1", {14'd0, miso_oe_o, miso_o}, 16'd0);
    if (nb == 16) chk("R5", 16'(pop_cnt - pops0), 16'd1);
    else          chk("R6", 16'(pop_cnt - pops0), 16'd0);
    nib_m = nib_m + 4'd1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R1", {14'd0, miso_oe_o, miso_o}, 16'd0);
    rst_ni = 1'b1;
    wait_n(2);
    // R1: serial clock while deselected must do nothing
    for (int i = 0; i < 4; i++) begin
      sclk_i = 1'b1; wait_n(6);
      chk("R1", {14'd0, miso_oe_o, miso_o}, 16'd0);
      sclk_i = 1'b0; wait_n(6);
    end
    chk("R1", 16'(pop_cnt), 16'd0);
    for (int t = 0; t < 40; t++) begin
      int nb;
      nb = (t % 7 == 6) ? (t % 16) : 16;
      xfer(nb, 3'(t), 8'(t * 37 + 11), (t % 5 == 3));
      wait_n(3);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule